// File: doc/BRIEF.md
# Fixed-Priority Interrupt Dispatcher

This block sits beside a small processor core and chooses which of five interrupt sources is served next. The sources are vertical blank, LCD status, timer, serial link and joypad. Each source raises a one-cycle pulse. The pulse latches a bit in a pending register. The core programs a mask register and a global interrupt-enable bit, and it can overwrite the pending register directly.

While the global enable is on, the block looks at the sources that are both pending and unmasked and picks the most urgent one. On the next clock edge it does three things: it drops that source's pending bit, turns the global enable off and issues a one-cycle dispatch strobe together with the source's entry address. The core is expected to push its return address and jump to that address; that work is not part of this block.

A separate wake output tells a halted core that some request is pending. This output looks only at the pending bits. It ignores both the mask and the global enable.

Top module: `int_dispatch`

## Requirements
- R1: After reset the pending bits, mask bits and global enable are all 0, and the strobe and wake outputs are low.
- R2: A pulse on `srcPulse` bit n sets pending bit n at the next edge. The bit map is vertical blank = 0, LCD status = 1, timer = 2, serial = 3, joypad = 4.
- R3: `enableWr` loads `enableData` into the mask register. `flagWr` loads `flagData` into the pending register. Both take effect at the next edge.
- R4: `masterSet` turns the global enable on and `masterClr` turns it off. When both are high in the same cycle, the global enable ends up off.
- R5: A dispatch takes place only when the global enable is on and some source has both its pending bit and its mask bit at 1. Otherwise the pending bits stay as they are and no strobe is issued.
- R6: When several sources are eligible, the lowest bit number wins. The order is vertical blank, then LCD status, timer, serial and joypad.
- R7: The entry address presented with the strobe is 0x40 for bit 0, 0x48 for bit 1, 0x50 for bit 2, 0x58 for bit 3 and 0x60 for bit 4.
- R8: A dispatch clears the global enable and only the served pending bit. All other pending bits stay set. The strobe lasts a single cycle.
- R9: A pending vertical-blank request can be served only while `lcdOn` is high. While `lcdOn` is low, arbitration passes to the next eligible source, and the vertical-blank bit stays pending.
- R10: `wake` is high whenever any pending bit is set, whatever the mask and the global enable hold.
- R11: A source pulse that arrives in the same cycle as the dispatch that clears its bit keeps that bit set.
- R12: A direct write of the pending register is ORed with source pulses arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | 5 | One-cycle request pulses, one per source |
| lcdOn | input | 1 | LCD enable; gates vertical-blank service |
| enableWr | input | 1 | Mask register write strobe |
| enableData | input | 5 | Mask register write value |
| flagWr | input | 1 | Pending register write strobe |
| flagData | input | 5 | Pending register write value |
| masterSet | input | 1 | Turn the global enable on |
| masterClr | input | 1 | Turn the global enable off |
| flagsOut | output | 5 | Pending register |
| enablesOut | output | 5 | Mask register |
| masterOn | output | 1 | Global enable state |
| dispatchStrobe | output | 1 | One-cycle dispatch pulse |
| dispatchVector | output | 8 | Entry address of the served source |
| wake | output | 1 | Halt release request |

## Verification
Two things can land on the same clock edge: a source's new pulse and the dispatch clear of that source's pending bit. The bench arranges this by keeping the timer pulse high across the exact edge where the timer request is dispatched. It then expects two results after that edge: the entry address arrives in the scoreboard, and the timer bit is still pending with the global enable off. A second global enable must then produce a second timer dispatch, which confirms that the late pulse was not lost. A pending-register write that coincides with a pulse is judged the same way, by reading back the merged pending bits.

// File: rtl/int_dispatch_pkg.sv
package int_dispatch_pkg;
  // Width of the source index carried from control to datapath (up to 8 sources).
  localparam int unsigned IDX_W = 3;

  // Strobes from the arbitration control to the register datapath.
  typedef struct packed {
    logic             fire;    // a dispatch happens at this edge
    logic [IDX_W-1:0] srcIdx;  // the source being served
  } dispCtl_t;
endpackage

// File: rtl/int_dispatch_ctrl.sv
module int_dispatch_ctrl
  import int_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 5,
  parameter int unsigned GATED_SRC = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] enables,
  input  logic               lcdOn,
  input  logic               masterSet,
  input  logic               masterClr,
  output logic               masterOn,
  output dispCtl_t           ctl
);
  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   pick;
  logic               anyEligible;

  // A source is eligible when both its pending and its mask bit are set.
  // The display-gated source also needs the LCD to be on.
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_elig
    if (gi == GATED_SRC) begin : g_gated
      assign eligible[gi] = flags[gi] & enables[gi] & lcdOn;
    end else begin : g_plain
      assign eligible[gi] = flags[gi] & enables[gi];
    end
  end

  // Fixed priority: the lowest index wins, so the scan runs downward.
  always_comb begin
    pick        = '0;
    anyEligible = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pick        = IDX_W'(i);
        anyEligible = 1'b1;
      end
    end
  end

  always_comb begin
    ctl.fire   = masterOn & anyEligible;
    ctl.srcIdx = pick;
  end

  // Clearing wins over setting, whether the clear comes from a dispatch
  // or from the core.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterOn <= 1'b0;
    end else if (ctl.fire || masterClr) begin
      masterOn <= 1'b0;
    end else if (masterSet) begin
      masterOn <= 1'b1;
    end
  end
endmodule

// File: rtl/int_dispatch_dp.sv
module int_dispatch_dp
  import int_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 5,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 'h40,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               enableWr,
  input  logic [NUM_SRC-1:0] enableData,
  input  logic               flagWr,
  input  logic [NUM_SRC-1:0] flagData,
  input  dispCtl_t           ctl,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic               strobe,
  output logic [VEC_W-1:0]   vector
);
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] flagsNext;
  logic [VEC_W-1:0]   vecNext;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_clr
    assign clrMask[gi] = ctl.fire && (ctl.srcIdx == IDX_W'(gi));
  end

  // A direct write replaces the clear path. New pulses are always ORed in last.
  always_comb begin
    flagsNext = (flagWr ? flagData : (flags & ~clrMask)) | srcPulse;
  end

  assign vecNext = VEC_W'(VEC_BASE + VEC_STEP * 32'(ctl.srcIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
      strobe  <= 1'b0;
      vector  <= '0;
    end else begin
      flags  <= flagsNext;
      strobe <= ctl.fire;
      vector <= ctl.fire ? vecNext : '0;
      if (enableWr) begin
        enables <= enableData;
      end
    end
  end
endmodule

// File: rtl/int_dispatch.sv
module int_dispatch
  import int_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 5,
  parameter int unsigned GATED_SRC = 0,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned VEC_BASE  = 'h40,
  parameter int unsigned VEC_STEP  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               lcdOn,
  input  logic               enableWr,
  input  logic [NUM_SRC-1:0] enableData,
  input  logic               flagWr,
  input  logic [NUM_SRC-1:0] flagData,
  input  logic               masterSet,
  input  logic               masterClr,
  output logic [NUM_SRC-1:0] flagsOut,
  output logic [NUM_SRC-1:0] enablesOut,
  output logic               masterOn,
  output logic               dispatchStrobe,
  output logic [VEC_W-1:0]   dispatchVector,
  output logic               wake
);
  dispCtl_t ctl;

  int_dispatch_ctrl #(
    .NUM_SRC  (NUM_SRC),
    .GATED_SRC(GATED_SRC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flags    (flagsOut),
    .enables  (enablesOut),
    .lcdOn    (lcdOn),
    .masterSet(masterSet),
    .masterClr(masterClr),
    .masterOn (masterOn),
    .ctl      (ctl)
  );

  int_dispatch_dp #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcPulse  (srcPulse),
    .enableWr  (enableWr),
    .enableData(enableData),
    .flagWr    (flagWr),
    .flagData  (flagData),
    .ctl       (ctl),
    .flags     (flagsOut),
    .enables   (enablesOut),
    .strobe    (dispatchStrobe),
    .vector    (dispatchVector)
  );

  // Halt release looks only at the pending bits, not at the mask or the global enable.
  assign wake = |flagsOut;
endmodule

// File: rtl/int_dispatch_checker.sv
module int_dispatch_checker #(
  parameter int unsigned NUM_SRC   = 5,
  parameter int unsigned GATED_SRC = 0,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned VEC_BASE  = 'h40,
  parameter int unsigned VEC_STEP  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcPulse,
  input logic               lcdOn,
  input logic               flagWr,
  input logic [NUM_SRC-1:0] flagsOut,
  input logic [NUM_SRC-1:0] enablesOut,
  input logic               masterOn,
  input logic               dispatchStrobe,
  input logic [VEC_W-1:0]   dispatchVector,
  input logic               wake
);
  logic [NUM_SRC-1:0] servedMask;
  logic [NUM_SRC-1:0] readyMask;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_map
    assign servedMask[gi] = (dispatchVector == VEC_W'(VEC_BASE + gi * VEC_STEP));
    if (gi == GATED_SRC) begin : g_g
      assign readyMask[gi] = flagsOut[gi] & enablesOut[gi] & lcdOn;
    end else begin : g_p
      assign readyMask[gi] = flagsOut[gi] & enablesOut[gi];
    end
  end

  // R5: a dispatch needs the global enable in the cycle before it.
  assert_needs_master_R5: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe |-> $past(masterOn));

  // R7: the vector matches exactly one source.
  assert_vector_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe |-> ($countones(servedMask) == 1));

  // R6: no higher-priority source was ready when this one was picked.
  assert_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe |-> (($past(readyMask) & (servedMask - 1'b1)) == '0));

  // R8: the global enable drops, and the strobe is a single cycle.
  assert_master_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe |-> !masterOn);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe |=> !dispatchStrobe);

  // R8/R11: the served bit is clear unless a pulse or a write refilled it.
  assert_served_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe && !$past(flagWr) |-> ((flagsOut & servedMask & ~$past(srcPulse)) == '0));

  // R9: vertical blank is served only while the LCD is on.
  assert_lcd_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    dispatchStrobe && servedMask[GATED_SRC] |-> $past(lcdOn));

  // R2: a pulse always leaves its bit set.
  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (($past(srcPulse) & ~flagsOut) == '0));

  // R10: any pulse leads to a raised wake.
  assert_wake_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srcPulse) != '0) |-> wake);
endmodule

bind int_dispatch int_dispatch_checker #(
  .NUM_SRC  (NUM_SRC),
  .GATED_SRC(GATED_SRC),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .srcPulse      (srcPulse),
  .lcdOn         (lcdOn),
  .flagWr        (flagWr),
  .flagsOut      (flagsOut),
  .enablesOut    (enablesOut),
  .masterOn      (masterOn),
  .dispatchStrobe(dispatchStrobe),
  .dispatchVector(dispatchVector),
  .wake          (wake)
);

// File: tb/int_dispatch_bench.sv
`timescale 1ns/1ps
module int_dispatch_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] srcPulse = '0;
  logic       lcdOn = 1'b1;
  logic       enableWr = 1'b0;
  logic [4:0] enableData = '0;
  logic       flagWr = 1'b0;
  logic [4:0] flagData = '0;
  logic       masterSet = 1'b0;
  logic       masterClr = 1'b0;
  logic [4:0] flagsOut;
  logic [4:0] enablesOut;
  logic       masterOn;
  logic       dispatchStrobe;
  logic [7:0] dispatchVector;
  logic       wake;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  int_dispatch u_int_dispatch (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .lcdOn(lcdOn),
    .enableWr(enableWr), .enableData(enableData), .flagWr(flagWr), .flagData(flagData),
    .masterSet(masterSet), .masterClr(masterClr), .flagsOut(flagsOut),
    .enablesOut(enablesOut), .masterOn(masterOn), .dispatchStrobe(dispatchStrobe),
    .dispatchVector(dispatchVector), .wake(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe pops one expected entry address (R6 R7).
  always @(negedge clk) begin
    if (rstN && dispatchStrobe) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R5: actual dispatch 0x%0h expected none", dispatchVector);
      end else begin
        check("R7 entry address", 32'(dispatchVector), 32'(expQ.pop_front()));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseSrc(input logic [4:0] m);
    @(negedge clk); srcPulse = m;
    @(negedge clk); srcPulse = '0;
  endtask

  task automatic setMaster();
    @(negedge clk); masterSet = 1'b1;
    @(negedge clk); masterSet = 1'b0;
  endtask

  task automatic clrMaster();
    @(negedge clk); masterClr = 1'b1;
    @(negedge clk); masterClr = 1'b0;
  endtask

  task automatic writeEn(input logic [4:0] d);
    @(negedge clk); enableWr = 1'b1; enableData = d;
    @(negedge clk); enableWr = 1'b0;
  endtask

  task automatic writeFlags(input logic [4:0] d);
    @(negedge clk); flagWr = 1'b1; flagData = d;
    @(negedge clk); flagWr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 flags", 32'(flagsOut), 0);
    check("R1 enables", 32'(enablesOut), 0);
    check("R1 master", 32'(masterOn), 0);
    check("R1 strobe", 32'(dispatchStrobe), 0);
    check("R1 wake", 32'(wake), 0);
    rstN = 1'b1;
    idle(1);

    // R3 mask write, R4 global enable set
    writeEn(5'h1F);
    check("R3 enables", 32'(enablesOut), 32'h1F);
    setMaster();
    check("R4 master set", 32'(masterOn), 1);

    // Single timer request
    expQ.push_back(8'h50);
    pulseSrc(5'b00100);
    check("R2 timer pending", 32'(flagsOut), 32'h04);
    idle(1);
    check("R8 flag cleared", 32'(flagsOut), 0);
    check("R8 master cleared", 32'(masterOn), 0);

    // R5: everything pending with the global enable off, then R6 order
    pulseSrc(5'h1F);
    check("R2 all pending", 32'(flagsOut), 32'h1F);
    check("R10 wake", 32'(wake), 1);
    idle(2);
    check("R5 held without master", 32'(flagsOut), 32'h1F);
    for (int k = 0; k < 5; k++) begin
      expQ.push_back(8'(8'h40 + 8 * k));
      setMaster();
      idle(1);
      check("R6 remaining pending", 32'(flagsOut), 32'((5'h1F << (k + 1)) & 5'h1F));
      check("R8 master after dispatch", 32'(masterOn), 0);
    end

    // R9: vertical blank gated by the LCD
    lcdOn = 1'b0;
    pulseSrc(5'b01001);
    expQ.push_back(8'h58);
    setMaster();
    idle(1);
    check("R9 vblank still pending", 32'(flagsOut), 32'h01);
    setMaster();
    idle(2);
    check("R9 no service while lcd off", 32'(masterOn), 1);
    check("R9 vblank held", 32'(flagsOut), 32'h01);
    expQ.push_back(8'h40);
    lcdOn = 1'b1;
    idle(1);
    check("R9 vblank served", 32'(flagsOut), 0);

    // R5 and R10: masked request does not dispatch but still wakes
    writeEn(5'b10000);
    pulseSrc(5'b00100);
    setMaster();
    idle(3);
    check("R5 masked held", 32'(flagsOut), 32'h04);
    check("R5 master kept", 32'(masterOn), 1);
    check("R10 wake when masked", 32'(wake), 1);
    clrMaster();
    check("R4 master clear", 32'(masterOn), 0);
    writeFlags(5'b10001);
    check("R3 flag write", 32'(flagsOut), 32'h11);
    writeFlags(5'b00000);
    check("R3 flag write zero", 32'(flagsOut), 0);
    check("R10 wake low", 32'(wake), 0);

    // R11: pulse on the dispatch edge of the same source
    writeEn(5'h1F);
    setMaster();
    @(negedge clk); srcPulse = 5'b00100;
    expQ.push_back(8'h50);
    @(negedge clk);
    @(negedge clk); srcPulse = '0;
    check("R11 bit kept", 32'(flagsOut), 32'h04);
    check("R11 master cleared", 32'(masterOn), 0);
    expQ.push_back(8'h50);
    setMaster();
    idle(1);
    check("R11 second service", 32'(flagsOut), 0);

    // R4: set and clear together
    @(negedge clk); masterSet = 1'b1; masterClr = 1'b1;
    @(negedge clk); masterSet = 1'b0; masterClr = 1'b0;
    check("R4 clear wins", 32'(masterOn), 0);

    // R12: write merged with a pulse
    @(negedge clk); flagWr = 1'b1; flagData = 5'b00010; srcPulse = 5'b01000;
    @(negedge clk); flagWr = 1'b0; srcPulse = '0;
    check("R12 merged flags", 32'(flagsOut), 32'h0A);

    idle(2);
    check("R7 scoreboard drained", 32'(expQ.size()), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule